// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of software-programmed address windows and steers a 36-bit physical address to a device target. Software writes, per window, a control word (enable, barrier flag, target, attribute, size mask), a base word and, on the windows that have one, a remap base. A lookup compares the address against every window at the same time. It returns a hit flag, the winning window number, the 4-bit target and 8-bit attribute of that window, and an output address. On a window with remap the output address is translated.

The size field holds the window size in 64 KB units, minus one, so it acts directly as a mask over address bits 35:16. When two or more enabled windows claim the same address, the lowest-numbered one is used and a sticky overlap flag is raised. Software can read that flag and clear it. Results are registered and appear one clock after the address.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads zero, the result outputs are zero and the overlap flag is low.
- R2: A write to word index 4*w+0 sets window w's control: enable in bit 0, barrier flag in bit 1, target in bits 7:4, attribute in bits 15:8, size-minus-one (64 KB units) in bits 31:16. Reading it back returns these fields, with bits 3:2 zero.
- R3: A write to word index 4*w+1 sets window w's base: address bits 31:16 from data bits 31:16 and address bits 35:32 from data bits 3:0. It reads back with all other bits zero.
- R4: An enabled window w matches address A when (A[35:16] AND NOT zero-extended size mask) equals its 20-bit base. The result then gives hit=1, the window number, its target and its attribute.
- R5: A window whose enable bit is clear never matches, whatever its other fields hold.
- R6: When several enabled windows match, the result reports the lowest-numbered one.
- R7: A lookup that matches two or more windows sets a sticky overlap flag. The flag shows on ovl_err and at bit 0 of word index 4*NUM_WIN. Writing 1 to that bit clears it, but a new overlap in the same cycle wins.
- R8: For windows numbered below NUM_REMAP, word index 4*w+2 bits 31:16 hold remap bits 31:16 and word 4*w+3 bits 3:0 hold remap bits 35:32. On a hit, output bits 35:16 equal the remap base OR (A[35:16] AND mask).
- R9: Windows numbered NUM_REMAP and up ignore remap writes, read remap words as zero, and pass the address through untranslated on a hit.
- R10: A lookup that misses returns hit=0, window 0, target 0 and attribute 0, with the address passed through unchanged.
- R11: A result appears exactly one clock after lk_valid is presented. A register write in the same cycle as a lookup affects only later lookups. Cycles without a lookup return zero on all result fields.
- R12: Output address bits 15:0 always equal the looked-up address bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | RA_W | Word index of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | RA_W | Word index of the read |
| reg_rd_data | output | 32 | Read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to decode |
| rs_valid | output | 1 | Result valid, one clock after lk_valid |
| rs_hit | output | 1 | A window matched |
| rs_win | output | WI_W | Winning window number |
| rs_target | output | 4 | Target of the winning window |
| rs_attr | output | 8 | Attribute of the winning window |
| rs_addr | output | 36 | Translated or passed-through address |
| ovl_err | output | 1 | Sticky overlap flag |

## Verification
The timing and pass-through assertions assume that lk_valid is held low while reset is asserted, so the first result after reset compares against a quiet request. The stimulus does this and drives inputs only on falling edges. The overlap-flag assertion assumes that the only clear is a write of 1 to the status word. The bench never writes other words at that index. Windows are programmed with legal power-of-two sizes and aligned bases. The one exception is a deliberate overlap between a large and a small window, which exercises priority and the sticky flag.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int PA_W   = 36;
    localparam int PAGE_W = 20;
    localparam int SZ_W   = 16;

    typedef struct packed {
        logic              en;
        logic              sync;
        logic [3:0]        tgt;
        logic [7:0]        attr;
        logic [SZ_W-1:0]   szm;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] remap;
    } win_cfg_t;
endpackage

// File: rtl/awd_win_slot.sv
module awd_win_slot #(
    parameter bit HAS_REMAP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    output awd_pkg::win_cfg_t cfg
);
    awd_pkg::win_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                2'd0: begin
                    cfg_d.en   = wdata[0];
                    cfg_d.sync = wdata[1];
                    cfg_d.tgt  = wdata[7:4];
                    cfg_d.attr = wdata[15:8];
                    cfg_d.szm  = wdata[31:16];
                end
                2'd1: cfg_d.base = {wdata[3:0], wdata[31:16]};
                2'd2: if (HAS_REMAP) cfg_d.remap[15:0] = wdata[31:16];
                default: if (HAS_REMAP) cfg_d.remap[19:16] = wdata[3:0];
            endcase
        end
        if (!HAS_REMAP) cfg_d.remap = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
    parameter bit HAS_REMAP = 1'b1
) (
    input  awd_pkg::win_cfg_t          cfg,
    input  logic [awd_pkg::PAGE_W-1:0] page,
    output logic                       hit,
    output logic [awd_pkg::PAGE_W-1:0] xpage
);
    localparam int PW = awd_pkg::PAGE_W;
    logic [PW-1:0] mask;

    assign mask = PW'(cfg.szm);
    assign hit  = cfg.en && ((page & ~mask) == cfg.base);

    generate
        if (HAS_REMAP) begin : g_rmp
            assign xpage = cfg.remap | (page & mask);
        end else begin : g_thru
            assign xpage = page;
        end
    endgenerate
endmodule

// File: rtl/awd_win_pick.sv
module awd_win_pick #(
    parameter int NUM_WIN = 8,
    localparam int WI_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0]         hits,
    input  awd_pkg::win_cfg_t          cfg   [NUM_WIN],
    input  logic [awd_pkg::PAGE_W-1:0] xpage [NUM_WIN],
    output logic                       any,
    output logic                       multi,
    output logic [WI_W-1:0]            idx,
    output logic [3:0]                 tgt,
    output logic [7:0]                 attr,
    output logic [awd_pkg::PAGE_W-1:0] xp
);
    always_comb begin
        idx  = '0;
        tgt  = '0;
        attr = '0;
        xp   = '0;
        // descending scan: the last assignment is the lowest index
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx  = WI_W'(i);
                tgt  = cfg[i].tgt;
                attr = cfg[i].attr;
                xp   = xpage[i];
            end
        end
    end

    assign any   = |hits;
    assign multi = ($countones(hits) > 1);
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int RA_W = $clog2(NUM_WIN * 4 + 1),
    localparam int WI_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic [RA_W-1:0] reg_wr_addr,
    input  logic [31:0]     reg_wr_data,
    input  logic [RA_W-1:0] reg_rd_addr,
    output logic [31:0]     reg_rd_data,
    input  logic            lk_valid,
    input  logic [35:0]     lk_addr,
    output logic            rs_valid,
    output logic            rs_hit,
    output logic [WI_W-1:0] rs_win,
    output logic [3:0]      rs_target,
    output logic [7:0]      rs_attr,
    output logic [35:0]     rs_addr,
    output logic            ovl_err
);
    localparam int PW       = awd_pkg::PAGE_W;
    localparam int STAT_IDX = NUM_WIN * 4;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic [WI_W-1:0] win;
        logic [3:0]      tgt;
        logic [7:0]      attr;
        logic [35:0]     addr;
        logic            ovl;
    } res_t;

    awd_pkg::win_cfg_t cfg   [NUM_WIN];
    logic [PW-1:0]     xpage [NUM_WIN];
    logic [NUM_WIN-1:0] hits;
    logic              any, multi;
    logic [WI_W-1:0]   pidx;
    logic [3:0]        ptgt;
    logic [7:0]        pattr;
    logic [PW-1:0]     pxp;
    logic              st_clr;
    res_t              res_d, res_q;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            localparam bit RMP = (w < NUM_REMAP);
            logic slot_we;
            assign slot_we = reg_wr_en && (reg_wr_addr[RA_W-1:2] == (RA_W-2)'(w));

            awd_win_slot #(.HAS_REMAP(RMP)) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (slot_we),
                .sel   (reg_wr_addr[1:0]),
                .wdata (reg_wr_data),
                .cfg   (cfg[w])
            );

            awd_win_match #(.HAS_REMAP(RMP)) u_match (
                .cfg   (cfg[w]),
                .page  (lk_addr[35:16]),
                .hit   (hits[w]),
                .xpage (xpage[w])
            );
        end
    endgenerate

    awd_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hits  (hits),
        .cfg   (cfg),
        .xpage (xpage),
        .any   (any),
        .multi (multi),
        .idx   (pidx),
        .tgt   (ptgt),
        .attr  (pattr),
        .xp    (pxp)
    );

    assign st_clr = reg_wr_en && (reg_wr_addr == RA_W'(STAT_IDX)) && reg_wr_data[0];

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_valid;
        if (lk_valid) begin
            res_d.addr = lk_addr;
            if (any) begin
                res_d.hit  = 1'b1;
                res_d.win  = pidx;
                res_d.tgt  = ptgt;
                res_d.attr = pattr;
                res_d.addr = {pxp, lk_addr[15:0]};
            end
        end
        res_d.ovl = (st_clr ? 1'b0 : res_q.ovl) | (lk_valid & multi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_addr == RA_W'(STAT_IDX)) begin
            reg_rd_data = {31'b0, res_q.ovl};
        end else begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (reg_rd_addr[RA_W-1:2] == (RA_W-2)'(i)) begin
                    case (reg_rd_addr[1:0])
                        2'd0: reg_rd_data = {cfg[i].szm, cfg[i].attr, cfg[i].tgt,
                                             2'b00, cfg[i].sync, cfg[i].en};
                        2'd1: reg_rd_data = {cfg[i].base[15:0], 12'b0, cfg[i].base[19:16]};
                        2'd2: reg_rd_data = {cfg[i].remap[15:0], 16'b0};
                        default: reg_rd_data = {28'b0, cfg[i].remap[19:16]};
                    endcase
                end
            end
        end
    end

    assign rs_valid  = res_q.valid;
    assign rs_hit    = res_q.hit;
    assign rs_win    = res_q.win;
    assign rs_target = res_q.tgt;
    assign rs_attr   = res_q.attr;
    assign rs_addr   = res_q.addr;
    assign ovl_err   = res_q.ovl;
endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int RA_W = $clog2(NUM_WIN * 4 + 1),
    localparam int WI_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr_en,
    input logic [RA_W-1:0] reg_wr_addr,
    input logic [31:0]     reg_wr_data,
    input logic            lk_valid,
    input logic [35:0]     lk_addr,
    input logic            rs_valid,
    input logic            rs_hit,
    input logic [WI_W-1:0] rs_win,
    input logic [3:0]      rs_target,
    input logic [7:0]      rs_attr,
    input logic [35:0]     rs_addr,
    input logic            ovl_err
);
    localparam int STAT_IDX = NUM_WIN * 4;

    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rs_valid == $past(lk_valid)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && rs_target == 4'd0 && rs_attr == 8'd0));

    a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_target == 4'd0 && rs_attr == 8'd0 && rs_win == '0));

    a_r10_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_addr == $past(lk_addr)));

    a_r12_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_addr[15:0] == $past(lk_addr[15:0])));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_err && !(reg_wr_en && reg_wr_addr == RA_W'(STAT_IDX) && reg_wr_data[0]))
        |=> ovl_err);
endmodule

bind addr_win_decoder awd_chk #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .lk_valid    (lk_valid),
    .lk_addr     (lk_addr),
    .rs_valid    (rs_valid),
    .rs_hit      (rs_hit),
    .rs_win      (rs_win),
    .rs_target   (rs_target),
    .rs_attr     (rs_attr),
    .rs_addr     (rs_addr),
    .ovl_err     (ovl_err)
);

// File: tb/addr_win_decoder_test.sv
`timescale 1ns/1ps
module addr_win_decoder_test;
    localparam int NW   = 8;
    localparam int NR   = 4;
    localparam int RA_W = $clog2(NW * 4 + 1);
    localparam int WI_W = $clog2(NW);
    localparam int STAT = NW * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic [RA_W-1:0] reg_wr_addr = '0;
    logic [31:0]     reg_wr_data = '0;
    logic [RA_W-1:0] reg_rd_addr = '0;
    logic [31:0]     reg_rd_data;
    logic            lk_valid = 1'b0;
    logic [35:0]     lk_addr = '0;
    logic            rs_valid, rs_hit, ovl_err;
    logic [WI_W-1:0] rs_win;
    logic [3:0]      rs_target;
    logic [7:0]      rs_attr;
    logic [35:0]     rs_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    addr_win_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_win(rs_win),
        .rs_target(rs_target), .rs_attr(rs_attr), .rs_addr(rs_addr),
        .ovl_err(ovl_err)
    );

    // behavioural reference state
    bit        m_en   [NW];
    bit [3:0]  m_tgt  [NW];
    bit [7:0]  m_attr [NW];
    bit [19:0] m_msk  [NW];
    bit [19:0] m_base [NW];
    bit [19:0] m_rmp  [NW];
    bit        m_ovl;

    bit        e_valid, e_hit, e_ovl;
    int        e_win;
    bit [3:0]  e_tgt;
    bit [7:0]  e_attr;
    bit [35:0] e_addr;
    bit [15:0] e_low;
    string     e_tag = "R1";

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(e_tag, "valid", rs_valid, e_valid);
        chk(e_tag, "hit", rs_hit, e_hit);
        chk(e_tag, "win", rs_win, e_win);
        chk(e_tag, "target", rs_target, e_tgt);
        chk(e_tag, "attr", rs_attr, e_attr);
        chk(e_tag, "addr", rs_addr, e_addr);
        chk(e_tag, "ovl", ovl_err, e_ovl);
        if (e_valid) chk("R12", "low addr bits", rs_addr[15:0], e_low);
    endtask

    task automatic model_write(input int wa, input bit [31:0] wd);
        int w = wa / 4;
        if (wa == STAT) return;
        if (w >= NW) return;
        case (wa % 4)
            0: begin
                m_en[w] = wd[0]; m_tgt[w] = wd[7:4];
                m_attr[w] = wd[15:8]; m_msk[w] = {4'h0, wd[31:16]};
            end
            1: m_base[w] = {wd[3:0], wd[31:16]};
            2: if (w < NR) m_rmp[w][15:0] = wd[31:16];
            default: if (w < NR) m_rmp[w][19:16] = wd[3:0];
        endcase
    endtask

    // one clock: check previous result, drive inputs, predict, advance
    task automatic cyc(input bit we, input int wa, input bit [31:0] wd,
                       input bit lv, input bit [35:0] la, input string tag);
        int cnt = 0;
        bit clr;
        compare();
        reg_wr_en = we; reg_wr_addr = RA_W'(wa); reg_wr_data = wd;
        lk_valid = lv; lk_addr = la;
        e_valid = lv; e_hit = 0; e_win = 0; e_tgt = 0; e_attr = 0;
        e_addr = lv ? la : 36'h0; e_low = la[15:0]; e_tag = tag;
        for (int i = 0; i < NW; i++) begin
            if (m_en[i] && ((la[35:16] & ~m_msk[i]) == m_base[i])) begin
                cnt++;
                if (lv && !e_hit) begin
                    e_hit = 1; e_win = i; e_tgt = m_tgt[i]; e_attr = m_attr[i];
                    if (i < NR) e_addr = {m_rmp[i] | (la[35:16] & m_msk[i]), la[15:0]};
                end
            end
        end
        clr = we && (wa == STAT) && wd[0];
        m_ovl = (clr ? 1'b0 : m_ovl) | (lv && cnt > 1);
        e_ovl = m_ovl;
        if (we) model_write(wa, wd);
        @(negedge clk);
    endtask

    task automatic wr(input int wa, input bit [31:0] wd);
        cyc(1'b1, wa, wd, 1'b0, 36'h0, "R11");
    endtask

    task automatic look(input bit [35:0] la, input string tag);
        cyc(1'b0, 0, 32'h0, 1'b1, la, tag);
    endtask

    task automatic rd_chk(input int ra, input bit [31:0] exp, input string tag);
        reg_rd_addr = RA_W'(ra);
        #0.5;
        chk(tag, "readback", reg_rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_en[i] = 0; m_tgt[i] = 0; m_attr[i] = 0;
            m_msk[i] = 0; m_base[i] = 0; m_rmp[i] = 0;
        end
        m_ovl = 0; e_valid = 0; e_hit = 0; e_ovl = 0; e_win = 0;
        e_tgt = 0; e_attr = 0; e_addr = 0; e_low = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet outputs and zeroed registers
        compare();
        rd_chk(0, 32'h0, "R1");
        rd_chk(6 * 4 + 1, 32'h0, "R1");
        rd_chk(STAT, 32'h0, "R1");

        // R2 / R3 / R8: program window 0 (1 MB at 0x1_2340_0000, remapped)
        wr(0, 32'h000F_A53F);
        wr(1, 32'h2340_0001);
        wr(2, 32'h8000_1234);
        wr(3, 32'hFFFF_FFF2);
        rd_chk(0, 32'h000F_A533, "R2");
        rd_chk(1, 32'h2340_0001, "R3");
        rd_chk(2, 32'h8000_0000, "R8");
        rd_chk(3, 32'h0000_0002, "R8");

        look(36'h1_2345_6789, "R8");
        look(36'h1_234F_FFFF, "R4");
        look(36'h1_2440_0000, "R10");
        look(36'h0_2345_6789, "R10");

        // R9: window 5 has no remap; 64 KB at 0x0_0003_0000
        wr(5 * 4 + 2, 32'hFFFF_0000);
        wr(5 * 4 + 3, 32'h0000_000F);
        rd_chk(5 * 4 + 2, 32'h0, "R9");
        rd_chk(5 * 4 + 3, 32'h0, "R9");
        wr(5 * 4 + 1, 32'h0003_0000);
        wr(5 * 4 + 0, 32'h0000_1171);
        look(36'h0_0003_1234, "R9");
        look(36'h0_0004_0000, "R10");

        // R6 / R7: window 2 covers 16 MB at 0 and overlaps window 5
        wr(2 * 4 + 1, 32'h0000_0000);
        wr(2 * 4 + 0, 32'h00FF_4C21);
        wr(2 * 4 + 2, 32'h4000_0000);
        look(36'h0_0003_1234, "R6");
        look(36'h0_0050_0000, "R7");
        rd_chk(STAT, 32'h1, "R7");
        cyc(1'b1, STAT, 32'h1, 1'b0, 36'h0, "R7");
        rd_chk(STAT, 32'h0, "R7");
        // clear and a new overlap in the same cycle: set wins
        cyc(1'b1, STAT, 32'h1, 1'b1, 36'h0_0003_0000, "R7");
        cyc(1'b1, STAT, 32'h1, 1'b0, 36'h0, "R7");
        look(36'h0_0001_0000, "R7");

        // R5: enable cleared with other fields kept
        wr(0, 32'h000F_A530);
        look(36'h1_2345_6789, "R5");
        // R11: write in the same cycle as a lookup affects only later ones
        cyc(1'b1, 0, 32'h000F_A531, 1'b1, 36'h1_2345_6789, "R11");
        look(36'h1_2345_6789, "R11");
        // zero control and base fully disables and clears window 0
        wr(0, 32'h0);
        wr(1, 32'h0);
        rd_chk(0, 32'h0, "R5");
        look(36'h1_2345_6789, "R5");
        look(36'h0_0000_0000, "R6");

        // R4: mixed lookups against the programmed windows
        wr(7 * 4 + 1, 32'h0000_0008);
        wr(7 * 4 + 0, 32'h0003_9961);
        wr(1 * 4 + 1, 32'h8000_0000);
        wr(1 * 4 + 0, 32'h7FFF_0111);
        wr(1 * 4 + 2, 32'h0001_0000);
        for (int n = 0; n < 300; n++) begin
            bit [35:0] a;
            a = {$urandom(), $urandom()};
            case (n % 5)
                0: a[35:18] = 18'h0;
                1: a[35:24] = 12'h0;
                2: a[35:20] = 16'h8000;
                3: a[35:32] = 4'h0;
                default: ;
            endcase
            cyc((n % 37) == 36, STAT, 32'h1, (n % 7) != 6, a, "R4");
        end
        cyc(1'b0, 0, 32'h0, 1'b0, 36'h0, "R11");
        compare();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule